// File: doc/BRIEF.md
# NAND Flash Controller Host Front End

This block sits between a processor register port and an 8-bit NAND flash bus. Software writes command, address and data bytes into dedicated registers; each write becomes one entry in a four-deep write queue. A strobe sequencer drains the queue in order and turns each entry into one bus cycle. CLE marks a command cycle and ALE an address cycle. WE# pulses low for writes and RE# pulses low for reads.

Reading takes two steps. A write of any value to the read-request register queues one read cycle. The byte the flash returns lands in a read-back register and raises a ready flag in the interrupt status register. Software clears that flag by writing a 1 to it. Software polls the queue-full status bit before each queued write.

Whole ECC sections can also be moved under hardware control. A page write start counts the queued data cycles until one section has been driven. A page read start issues a section's worth of read cycles on its own and streams each captured byte out on a side port. A self-clearing reset bit zeroes the section counter and emits a one-cycle clear pulse for an external ECC accumulator. The ready/busy pin is synchronised, and its rising edge is reported as an event.

Top module: `nfc_host_if`

## Requirements
- R1: After reset, status (address 0) reads 0x11 with the ready pin high, interrupt status (address 1) reads 0x00, and control (address 2) reads 0x01.
- R2: A write to address 8 queues a cycle with CLE high. A write to address 9 queues a cycle with ALE high. A write to address 10 queues a plain data cycle. In each case the written byte is driven on the data bus while WE# is low, and CLE and ALE are never both high.
- R3: Queue entries reach the bus in write order. Each strobe stays low for exactly STROBE_LO (2) clocks, and two strobes are separated by at least STROBE_HI (2) high clocks.
- R4: The queue holds WB_DEPTH (4) entries, and status bit 1 is high while it is full. A queued write arriving while the queue is full is discarded and sets interrupt bit 1.
- R5: Interrupt bit 2 sets when the queue goes from full to not full. Status bit 4 is high whenever the queue is empty.
- R6: A write of any value to address 11 queues one RE# read cycle. The byte sampled at the end of the low phase is readable at address 12, and interrupt bit 3 sets.
- R7: Writing the interrupt status register clears each bit written as 1 and leaves each bit written as 0. An event that arrives in the same cycle as its clear leaves the bit set.
- R8: Status bit 0 follows the ready pin after a two-flop synchroniser, reacting on the second clock edge after the pin changes. Interrupt bit 0 sets when the synchronised value rises.
- R9: Writing 1 to bit 0 of address 3 makes that bit read 1 for one cycle and then 0, drives ecc_clear high for that cycle, and restarts the section byte count.
- R10: Writing 1 to bit 1 of address 4 starts a page write and sets status bit 2. The bit falls, and interrupt bit 4 sets, in the cycle the section's last data cycle completes.
- R11: Writing 1 to bit 0 of address 4 starts a page read and sets status bit 3. The block issues exactly one section of read cycles on its own, presents each captured byte on pg_rd_data with a one-cycle pg_rd_valid, and then clears bit 3.
- R12: Control bit 0 selects the section size: 1 gives SEC_LARGE (512) bytes and 0 gives SEC_SMALL (256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational on host_addr |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Data driven to the flash |
| nand_din | input | 8 | Data returned by the flash |
| nand_rb_n | input | 1 | Ready (high) / busy (low) pin, asynchronous |
| ecc_clear | output | 1 | One-cycle clear pulse for the ECC accumulator |
| pg_rd_valid | output | 1 | A page-read byte is present on pg_rd_data |
| pg_rd_data | output | 8 | Page-read byte |

## Verification
The interrupt register is where two functions can collide: a software write-1-to-clear of a flag and a hardware event setting that same flag can land in one clock. The bench provokes this by releasing the ready pin and timing a clear of interrupt bit 0 to coincide with the clock in which the synchroniser output rises. It then reads the register and requires the bit to still be set. A second collision is a queued write that arrives while the queue is full; the bench judges it by the overflow flag and by the exact set of bus cycles that appear afterwards.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_STAT  = 4'd0;
    localparam logic [ADDR_W-1:0] A_IRQ   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTL   = 4'd2;
    localparam logic [ADDR_W-1:0] A_RST   = 4'd3;
    localparam logic [ADDR_W-1:0] A_PGCTL = 4'd4;
    localparam logic [ADDR_W-1:0] A_READ  = 4'd12;
    // addresses 8..11 are queued; their low two bits select the cycle kind

    typedef enum logic [2:0] {
        K_CMD = 3'd0,
        K_ADR = 3'd1,
        K_DAT = 3'd2,
        K_RDQ = 3'd3,
        K_PRD = 3'd4
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] data;
    } entry_t;
endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic ready,
    output logic ready_rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], rb_async};
        d.prev = q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sync: '1, prev: 1'b1};
        else        q <= d;
    end

    assign ready      = q.sync[STAGES-1];
    assign ready_rise = q.sync[STAGES-1] && !q.prev;
endmodule

// File: rtl/nfc_wbuf.sv
module nfc_wbuf import nfc_pkg::*; #(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  entry_t push_data,
    input  logic   pop,
    output entry_t head,
    output logic   valid,
    output logic   full,
    output logic   empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t    q, d;
    entry_t mem [DEPTH];
    logic   do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (q.cnt == CNT_W'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign valid   = !empty;
    assign head    = mem[q.rd];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        d = q;
        if (do_push) d.wr = bump(q.wr);
        if (do_pop)  d.rd = bump(q.rd);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= push_data;
    end

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DEPTH));
    assert_full_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/nfc_strobe_seq.sv
module nfc_strobe_seq import nfc_pkg::*; #(
    parameter int STROBE_LO = 2,
    parameter int STROBE_HI = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       entry_valid,
    input  entry_t     entry,
    input  logic       auto_rd,
    input  logic [7:0] nand_din,
    output logic       pop,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dout,
    output logic       done,
    output kind_e      done_kind,
    output logic [7:0] rd_byte
);
    localparam int MAXPH = (STROBE_LO > STROBE_HI) ? STROBE_LO : STROBE_HI;
    localparam int CW    = $clog2(MAXPH + 1);

    typedef struct packed {
        logic          busy;
        logic          low;
        logic [CW-1:0] cnt;
        kind_e         kind;
        logic [7:0]    data;
    } st_t;

    st_t  q, d;
    logic is_rd;

    assign is_rd = (q.kind == K_RDQ) || (q.kind == K_PRD);

    always_comb begin
        d    = q;
        pop  = 1'b0;
        done = 1'b0;
        if (!q.busy) begin
            if (entry_valid) begin
                pop    = 1'b1;
                d.busy = 1'b1;
                d.low  = 1'b1;
                d.cnt  = '0;
                d.kind = entry.kind;
                d.data = entry.data;
            end else if (auto_rd) begin
                d.busy = 1'b1;
                d.low  = 1'b1;
                d.cnt  = '0;
                d.kind = K_PRD;
                d.data = '0;
            end
        end else if (q.low) begin
            if (q.cnt == CW'(STROBE_LO - 1)) begin
                d.low = 1'b0;
                d.cnt = '0;
                if (is_rd) d.data = nand_din;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            if (q.cnt == CW'(STROBE_HI - 1)) begin
                d.busy = 1'b0;
                done   = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, low: 1'b0, cnt: '0, kind: K_CMD, data: '0};
        else        q <= d;
    end

    assign cle       = q.busy && (q.kind == K_CMD);
    assign ale       = q.busy && (q.kind == K_ADR);
    assign we_n      = !(q.busy && q.low && !is_rd);
    assign re_n      = !(q.busy && q.low && is_rd);
    assign dout      = q.data;
    assign done_kind = q.kind;
    assign rd_byte   = q.data;

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    assert_cle_ale_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    assert_no_pop_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !pop);
    generate
        if (STROBE_LO >= 2) begin : g_lo_chk
            assert_we_low_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(we_n) |=> !we_n);
        end
    endgenerate
endmodule

// File: rtl/nfc_host_if.sv
module nfc_host_if import nfc_pkg::*; #(
    parameter int WB_DEPTH    = 4,
    parameter int STROBE_LO   = 2,
    parameter int STROBE_HI   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SEC_SMALL   = 256,
    parameter int SEC_LARGE   = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dout,
    input  logic [7:0]        nand_din,
    input  logic              nand_rb_n,
    output logic              ecc_clear,
    output logic              pg_rd_valid,
    output logic [7:0]        pg_rd_data
);
    localparam int SEC_W = $clog2(SEC_LARGE);

    typedef struct packed {
        logic [4:0]       irq;
        logic             ctl_large;
        logic             rst_pend;
        logic             pg_wr;
        logic             pg_rd;
        logic [SEC_W-1:0] xfer;
        logic [7:0]       rd_reg;
        logic             full_prev;
    } st_t;

    st_t        q, d;
    entry_t     push_entry, head;
    kind_e      done_kind;
    logic       q_write, push, wb_valid, wb_full, wb_empty, pop;
    logic       seq_done, ready, ready_rise, wr_finish;
    logic [7:0] rd_byte;
    logic [4:0] irq_set, irq_clr;
    logic [SEC_W-1:0] sec_last;

    assign q_write    = host_we && (host_addr[3:2] == 2'b10);
    assign push       = q_write;
    assign push_entry = '{kind: kind_e'({1'b0, host_addr[1:0]}), data: host_wdata};
    assign sec_last   = q.ctl_large ? SEC_W'(SEC_LARGE - 1) : SEC_W'(SEC_SMALL - 1);

    nfc_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
        .clk(clk), .rst_n(rst_n), .rb_async(nand_rb_n),
        .ready(ready), .ready_rise(ready_rise)
    );

    nfc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_entry),
        .pop(pop), .head(head), .valid(wb_valid), .full(wb_full), .empty(wb_empty)
    );

    nfc_strobe_seq #(.STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI)) u_seq (
        .clk(clk), .rst_n(rst_n), .entry_valid(wb_valid), .entry(head),
        .auto_rd(q.pg_rd), .nand_din(nand_din), .pop(pop),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .dout(nand_dout), .done(seq_done), .done_kind(done_kind), .rd_byte(rd_byte)
    );

    always_comb begin
        d         = q;
        wr_finish = 1'b0;
        d.full_prev = wb_full;

        if (host_we && host_addr == A_CTL) d.ctl_large = host_wdata[0];
        if (host_we && host_addr == A_PGCTL && !q.pg_wr && !q.pg_rd) begin
            if (host_wdata[0]) begin
                d.pg_rd = 1'b1;
                d.xfer  = '0;
            end else if (host_wdata[1]) begin
                d.pg_wr = 1'b1;
                d.xfer  = '0;
            end
        end

        if (seq_done && done_kind == K_DAT && q.pg_wr) begin
            if (q.xfer == sec_last) begin
                d.pg_wr   = 1'b0;
                d.xfer    = '0;
                wr_finish = 1'b1;
            end else begin
                d.xfer = q.xfer + 1'b1;
            end
        end
        if (seq_done && done_kind == K_PRD) begin
            if (q.xfer == sec_last) begin
                d.pg_rd = 1'b0;
                d.xfer  = '0;
            end else begin
                d.xfer = q.xfer + 1'b1;
            end
        end
        if (seq_done && done_kind == K_RDQ) d.rd_reg = rd_byte;

        if (q.rst_pend) begin
            d.rst_pend = 1'b0;
            d.xfer     = '0;
        end
        if (host_we && host_addr == A_RST && host_wdata[0]) d.rst_pend = 1'b1;

        irq_set = {wr_finish,
                   seq_done && done_kind == K_RDQ,
                   q.full_prev && !wb_full,
                   q_write && wb_full,
                   ready_rise};
        irq_clr = (host_we && host_addr == A_IRQ) ? host_wdata[4:0] : 5'd0;
        d.irq   = (q.irq & ~irq_clr) | irq_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{irq: '0, ctl_large: 1'b1, rst_pend: 1'b0, pg_wr: 1'b0,
                           pg_rd: 1'b0, xfer: '0, rd_reg: '0, full_prev: 1'b0};
        else        q <= d;
    end

    always_comb begin
        case (host_addr)
            A_STAT:  host_rdata = {3'b000, wb_empty, q.pg_rd, q.pg_wr, wb_full, ready};
            A_IRQ:   host_rdata = {3'b000, q.irq};
            A_CTL:   host_rdata = {7'd0, q.ctl_large};
            A_RST:   host_rdata = {7'd0, q.rst_pend};
            A_READ:  host_rdata = q.rd_reg;
            default: host_rdata = 8'd0;
        endcase
    end

    assign ecc_clear   = q.rst_pend;
    assign pg_rd_valid = seq_done && done_kind == K_PRD;
    assign pg_rd_data  = rd_byte;

    assert_overflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_write && wb_full) |=> q.irq[1]);
    assert_rst_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rst_pend && !(host_we && host_addr == A_RST && host_wdata[0])) |=> !q.rst_pend);
    assert_wr_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.pg_wr) |-> q.irq[4]);
    assert_ready_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_rise |=> q.irq[0]);
    assert_rd_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && done_kind == K_RDQ) |=> q.irq[3]);
endmodule

// File: tb/nfc_host_if_tb.sv
module nfc_host_if_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [3:0] host_addr = 4'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0] nand_dout;
    logic [7:0] din_v = 8'h40;
    logic       rb_v = 1'b1;
    logic       ecc_clear, pg_rd_valid;
    logic [7:0] pg_rd_data;

    int n_chk = 0, n_fail = 0, pg_cnt = 0;
    bit ended = 0, saw_clear = 0;
    logic [9:0] exp_q[$];

    always #4 clk = ~clk;

    nfc_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dout(nand_dout), .nand_din(din_v), .nand_rb_n(rb_v),
        .ecc_clear(ecc_clear), .pg_rd_valid(pg_rd_valid), .pg_rd_data(pg_rd_data)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [3:0] a, output logic [7:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_room();
        logic [7:0] s;
        host_rd(4'd0, s);
        while (s[1]) begin
            @(negedge clk);
            host_rd(4'd0, s);
        end
    endtask

    task automatic drain();
        logic [7:0] s;
        host_rd(4'd0, s);
        while (!s[4]) begin
            @(negedge clk);
            host_rd(4'd0, s);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic send_data(input logic [7:0] v);
        wait_room();
        exp_q.push_back({2'd2, v});
        host_wr(4'd10, v);
    endtask

    // scoreboard monitor: strobes against expected bus cycles, and strobe widths
    logic prev_lo = 1'b0;
    int   lo_w = 0, hi_w = 100;
    always @(negedge clk) begin
        logic       lo;
        logic [9:0] item;
        logic [1:0] code;
        lo = !nand_we_n || !nand_re_n;
        if (rst_n) begin
            if (lo && !prev_lo) begin
                chk(hi_w >= 2, "R3 strobe high gap", hi_w, 2);
                code = !nand_re_n ? 2'd3 : nand_cle ? 2'd0 : nand_ale ? 2'd1 : 2'd2;
                if (code == 2'd3) din_v = din_v + 8'h17;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected bus cycle", {code, nand_dout}, 0);
                end else begin
                    item = exp_q.pop_front();
                    if (code == 2'd3)
                        chk(item[9:8] == 2'd3, "R6 read cycle kind", code, item[9:8]);
                    else
                        chk(item == {code, nand_dout}, "R2 bus cycle kind and byte",
                            {code, nand_dout}, item);
                end
                lo_w = 1;
            end else if (lo) begin
                lo_w++;
            end
            if (!lo && prev_lo) begin
                chk(lo_w == 2, "R3 strobe low width", lo_w, 2);
                hi_w = 1;
            end else if (!lo) begin
                hi_w++;
            end
            if (pg_rd_valid) begin
                pg_cnt++;
                chk(pg_rd_data == din_v, "R11 page read byte", pg_rd_data, din_v);
            end
            if (ecc_clear) saw_clear = 1;
        end
        prev_lo = lo;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        host_rd(4'd0, v); chk(v == 8'h11, "R1 status after reset", v, 8'h11);
        host_rd(4'd1, v); chk(v == 8'h00, "R1 irq after reset", v, 8'h00);
        host_rd(4'd2, v); chk(v == 8'h01, "R1 control after reset", v, 8'h01);

        // R2 R3 command, address, data cycles in order
        exp_q.push_back({2'd0, 8'h70}); host_wr(4'd8, 8'h70);
        exp_q.push_back({2'd1, 8'h12}); host_wr(4'd9, 8'h12);
        exp_q.push_back({2'd2, 8'h5A}); host_wr(4'd10, 8'h5A);
        exp_q.push_back({2'd1, 8'hE3}); host_wr(4'd9, 8'hE3);
        drain();
        chk(exp_q.size() == 0, "R3 all queued cycles drained", exp_q.size(), 0);

        // R4 R5 burst of six back-to-back writes: the sixth meets a full queue
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            host_we = 1'b1; host_addr = 4'd10; host_wdata = 8'hA0 + 8'(i);
            if (i < 5) exp_q.push_back({2'd2, 8'hA0 + 8'(i)});
        end
        @(negedge clk);
        host_we = 1'b0;
        host_rd(4'd0, v); chk(v[1] == 1'b1, "R4 full status bit", v[1], 1);
        host_rd(4'd1, v); chk(v[1] == 1'b1, "R4 overflow flag", v[1], 1);
        drain();
        host_rd(4'd1, v); chk(v[2] == 1'b1, "R5 edge flag after leaving full", v[2], 1);
        host_rd(4'd0, v); chk(v[4] == 1'b1, "R5 empty status bit", v[4], 1);
        chk(exp_q.size() == 0, "R4 dropped write never reached the bus", exp_q.size(), 0);

        // R7 clear with 1, keep with 0
        host_wr(4'd1, 8'h02);
        host_rd(4'd1, v); chk(v[2:1] == 2'b10, "R7 partial clear", v[2:1], 2'b10);
        host_wr(4'd1, 8'h04);
        host_rd(4'd1, v); chk(v == 8'h00, "R7 flags cleared", v, 0);

        // R6 two-phase read
        exp_q.push_back({2'd3, 8'h00});
        host_wr(4'd11, 8'h99);
        drain();
        host_rd(4'd1, v);  chk(v[3] == 1'b1, "R6 read-ready flag", v[3], 1);
        host_rd(4'd12, v); chk(v == din_v, "R6 read-back byte", v, din_v);
        host_wr(4'd1, 8'h08);
        host_rd(4'd1, v);  chk(v[3] == 1'b0, "R7 read-ready cleared", v[3], 0);

        // R8 synchroniser latency and ready event
        @(negedge clk); rb_v = 1'b0;
        repeat (4) @(negedge clk);
        host_rd(4'd0, v); chk(v[0] == 1'b0, "R8 busy seen", v[0], 0);
        rb_v = 1'b1;
        @(negedge clk);
        host_rd(4'd0, v); chk(v[0] == 1'b0, "R8 not yet after one edge", v[0], 0);
        @(negedge clk);
        host_rd(4'd0, v); chk(v[0] == 1'b1, "R8 ready after two edges", v[0], 1);
        @(negedge clk);
        host_rd(4'd1, v); chk(v[0] == 1'b1, "R8 ready event flag", v[0], 1);

        // R7 clear coinciding with the event: set wins
        host_wr(4'd1, 8'h01);
        @(negedge clk); rb_v = 1'b0;
        repeat (4) @(negedge clk);
        rb_v = 1'b1;
        @(negedge clk);
        @(negedge clk);
        host_we = 1'b1; host_addr = 4'd1; host_wdata = 8'h01;
        @(negedge clk);
        host_we = 1'b0;
        host_rd(4'd1, v); chk(v[0] == 1'b1, "R7 event wins over same-cycle clear", v[0], 1);
        host_wr(4'd1, 8'h1F);

        // R10 R12 page write of a 256-byte section
        host_wr(4'd2, 8'h00);
        host_wr(4'd4, 8'h02);
        host_rd(4'd0, v); chk(v[2] == 1'b1, "R10 page write pending", v[2], 1);
        for (int i = 0; i < 255; i++) send_data(8'(i * 3));
        drain();
        host_rd(4'd0, v); chk(v[2] == 1'b1, "R12 still pending after 255 bytes", v[2], 1);
        host_rd(4'd1, v); chk(v[4] == 1'b0, "R10 no done before last byte", v[4], 0);
        send_data(8'hFE);
        drain();
        host_rd(4'd0, v); chk(v[2] == 1'b0, "R10 pending cleared", v[2], 0);
        host_rd(4'd1, v); chk(v[4] == 1'b1, "R10 done flag", v[4], 1);
        host_wr(4'd1, 8'h10);

        // R9 counter reset restarts the section count
        host_wr(4'd4, 8'h02);
        for (int i = 0; i < 10; i++) send_data(8'(i));
        drain();
        saw_clear = 0;
        host_wr(4'd3, 8'h01);
        host_rd(4'd3, v); chk(v[0] == 1'b1, "R9 reset bit reads 1", v[0], 1);
        @(negedge clk);
        host_rd(4'd3, v); chk(v[0] == 1'b0, "R9 reset bit self-clears", v[0], 0);
        chk(saw_clear, "R9 ecc_clear pulse", saw_clear, 1);
        for (int i = 0; i < 250; i++) send_data(8'(i + 7));
        drain();
        host_rd(4'd1, v); chk(v[4] == 1'b0, "R9 count restarted", v[4], 0);
        for (int i = 0; i < 6; i++) send_data(8'(i + 200));
        drain();
        host_rd(4'd1, v); chk(v[4] == 1'b1, "R9 done after full section", v[4], 1);
        host_wr(4'd1, 8'h10);

        // R11 R12 page reads, 256 then 512
        pg_cnt = 0;
        for (int i = 0; i < 256; i++) exp_q.push_back({2'd3, 8'h00});
        host_wr(4'd4, 8'h01);
        host_rd(4'd0, v); chk(v[3] == 1'b1, "R11 page read pending", v[3], 1);
        repeat (256 * 5 + 20) @(negedge clk);
        host_rd(4'd0, v); chk(v[3] == 1'b0, "R11 page read finished", v[3], 0);
        chk(pg_cnt == 256, "R12 small section byte count", pg_cnt, 256);

        host_wr(4'd2, 8'h01);
        pg_cnt = 0;
        for (int i = 0; i < 512; i++) exp_q.push_back({2'd3, 8'h00});
        host_wr(4'd4, 8'h01);
        repeat (256 * 5) @(negedge clk);
        host_rd(4'd0, v); chk(v[3] == 1'b1, "R12 large section still running", v[3], 1);
        repeat (256 * 5 + 20) @(negedge clk);
        host_rd(4'd0, v); chk(v[3] == 1'b0, "R11 large page read finished", v[3], 0);
        chk(pg_cnt == 512, "R12 large section byte count", pg_cnt, 512);
        chk(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);

        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule